// File: doc/BRIEF.md
# Disk Record Address Sequencer

This block keeps the record address of a moving-head disk controller. The address has three fields: an 8-bit cylinder, a 5-bit head and a 5-bit sector. The controller loads the address from two data words, one carrying the cylinder and one carrying head and sector. It then asks the block for permission before each sector transfer.

On every request the block checks that the stored cylinder matches the cylinder the drive is sitting on, and that the sector number is legal. If both hold, it grants the transfer and returns the flat word address of that sector in a linear storage array. It then steps to the next sector. A logical cylinder covers the two surfaces that differ only in the head's least significant bit. Running off the last sector flips that bit, and the block raises end-of-cylinder when the bit comes back to 0.

A check operation skips forward by a sector count in one step. Any count that would leave the two-track span parks the address at the start of the even track and raises end-of-cylinder. The remainder and quotient by 23 come from a small subtract-per-cycle divider, and a done pulse marks completion.

Top module: `rar_unit`

## Requirements
- R1: While reset is high and in the cycle after it falls, cylinder, head and sector read 0, and eoc, grant, addr_err, chk_busy and chk_done are 0.
- R2: ld_cyl loads the cylinder from data_in[7:0]. ld_hs loads the head from data_in[12:8] and the sector from data_in[4:0].
- R3: An accepted advance pulses grant in the next cycle. acc_addr then holds ((cyl*20+head)*23+sector)*128 of the address before the advance, and the sector has gone up by one.
- R4: An accepted advance from sector 22 sets the sector to 0 and inverts head bit 0. eoc is set when the inverted bit is 0, and otherwise eoc is left unchanged.
- R5: An advance when the cylinder differs from drive_cyl, or when the sector is 23 or more, pulses addr_err instead of grant and leaves the address unchanged.
- R6: While eoc is set and cmd_start is low, an advance is refused. It produces no grant and no addr_err, and the address is unchanged.
- R7: cmd_start clears eoc. In the same cycle, an advance is judged as if eoc were already clear. A wrap in that same cycle sets eoc again.
- R8: A load in the same cycle as an advance or a check start takes the load, and the other request is dropped.
- R9: chk_start takes the count from data_in[8:0]. If the count exceeds (2 - head[0])*23 - sector, the block sets eoc, clears head bit 0, sets the sector to 0, and pulses chk_done one cycle later.
- R10: If the count is within that limit, then with s = sector + count the sector becomes s mod 23 and head bit 0 is XORed with bit 0 of s div 23. chk_done appears 2 + (s div 23) cycles after the start cycle.
- R11: A check started when the cylinder differs from drive_cyl, or when the sector is 23 or more, pulses addr_err and chk_done one cycle later and leaves the address unchanged.
- R12: While chk_busy is high, advances, loads and check starts are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 13 | Address or count word |
| ld_cyl | input | 1 | Load cylinder from data_in[7:0] |
| ld_hs | input | 1 | Load head [12:8] and sector [4:0] |
| cmd_start | input | 1 | New command begins; clears eoc |
| adv | input | 1 | Request one sector access and advance |
| chk_start | input | 1 | Start a check with count data_in[8:0] |
| drive_cyl | input | 8 | Cylinder the drive is currently on |
| cyl | output | 8 | Record cylinder |
| head | output | 5 | Record head |
| sect | output | 5 | Record sector |
| eoc | output | 1 | End-of-cylinder latch |
| grant | output | 1 | Sector access granted (pulse) |
| addr_err | output | 1 | Address error (pulse) |
| acc_addr | output | 24 | Linear word address of the granted sector |
| chk_busy | output | 1 | Check division in progress |
| chk_done | output | 1 | Check finished (pulse) |

## Verification
A new-command strobe and a sector advance can land in the same cycle. The clear of end-of-cylinder must then let the advance through, and a wrap in that same cycle must set the latch again. The bench first brings eoc high with an overflowing check. It then raises cmd_start together with adv, and expects a grant, the sector moved on by one, and eoc low. A load colliding with an advance is provoked the same way, and the bench expects the newly loaded sector with no grant.

// File: rtl/rar_pkg.sv
package rar_pkg;

    localparam int NUM_SECT   = 23;
    localparam int NUM_HEAD   = 20;
    localparam int NUM_CYL    = 203;
    localparam int SECT_WORDS = 128;

    localparam int CYL_W      = 8;
    localparam int HEAD_W     = 5;
    localparam int SECT_W     = 5;
    localparam int CNT_W      = 9;
    localparam int HEAD_LSB   = 8;
    localparam int DATA_W     = HEAD_LSB + HEAD_W;
    localparam int SUM_W      = CNT_W + 1;
    localparam int ADDR_W     = $clog2(NUM_CYL * NUM_HEAD * NUM_SECT * SECT_WORDS);

    typedef struct packed {
        logic [CYL_W-1:0]  cyl;
        logic [HEAD_W-1:0] head;
        logic [SECT_W-1:0] sect;
    } rec_addr_t;

    // Sectors left in the two-track span from the current position.
    function automatic logic [SUM_W-1:0] span_left(logic head_lsb, logic [SECT_W-1:0] s);
        logic [SUM_W-1:0] span;
        span = head_lsb ? SUM_W'(NUM_SECT) : SUM_W'(2 * NUM_SECT);
        return span - SUM_W'(s);
    endfunction

endpackage

// File: rtl/rar_divmod.sv
module rar_divmod #(
    parameter int W     = 10,
    parameter int RW    = 5,
    parameter int DIVV  = 23
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [W-1:0]  dividend,
    output logic          busy,
    output logic          done,
    output logic [RW-1:0] rem,
    output logic          quo_lsb
);
    localparam logic [W-1:0] DIV_K = W'(DIVV);

    logic [W-1:0] rem_q;
    logic         par_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            rem_q <= '0;
            par_q <= 1'b0;
        end else if (start) begin
            busy  <= 1'b1;
            rem_q <= dividend;
            par_q <= 1'b0;
        end else if (busy) begin
            if (rem_q >= DIV_K) begin
                rem_q <= rem_q - DIV_K;
                par_q <= ~par_q;
            end else begin
                busy  <= 1'b0;
            end
        end
    end

    assign done    = busy && (rem_q < DIV_K);
    assign rem     = rem_q[RW-1:0];
    assign quo_lsb = par_q;

endmodule

// File: rtl/rar_lin_addr.sv
module rar_lin_addr
    import rar_pkg::*;
(
    input  rec_addr_t         rec,
    output logic [ADDR_W-1:0] word_addr
);
    localparam int WSH = $clog2(SECT_WORDS);

    logic [ADDR_W-1:0] track_idx;
    logic [ADDR_W-1:0] sect_idx;

    always_comb begin
        track_idx = ADDR_W'(rec.cyl) * ADDR_W'(NUM_HEAD) + ADDR_W'(rec.head);
        sect_idx  = track_idx * ADDR_W'(NUM_SECT) + ADDR_W'(rec.sect);
    end

    generate
        if ((1 << WSH) == SECT_WORDS) begin : g_shift
            assign word_addr = sect_idx << WSH;
        end else begin : g_mult
            assign word_addr = sect_idx * ADDR_W'(SECT_WORDS);
        end
    endgenerate

endmodule

// File: rtl/rar_unit.sv
module rar_unit
    import rar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [12:0]       data_in,
    input  logic              ld_cyl,
    input  logic              ld_hs,
    input  logic              cmd_start,
    input  logic              adv,
    input  logic              chk_start,
    input  logic [7:0]        drive_cyl,
    output logic [7:0]        cyl,
    output logic [4:0]        head,
    output logic [4:0]        sect,
    output logic              eoc,
    output logic              grant,
    output logic              addr_err,
    output logic [23:0]       acc_addr,
    output logic              chk_busy,
    output logic              chk_done
);

    rec_addr_t         rec_q;
    logic              eoc_q, grant_q, err_q, done_q;
    logic [ADDR_W-1:0] acc_q;
    logic [ADDR_W-1:0] lin_now;

    logic              div_busy, div_done, div_qlsb;
    logic [SECT_W-1:0] div_rem;

    logic              ld_any, idle, addr_bad, eoc_eff;
    logic              do_load, do_chk, do_adv;
    logic              adv_ok, adv_err;
    logic [CNT_W-1:0]  chk_cnt;
    logic [SUM_W-1:0]  chk_lim, chk_sum;
    logic              chk_over, div_start;

    always_comb begin
        ld_any    = ld_cyl || ld_hs;
        idle      = !div_busy;
        addr_bad  = (rec_q.cyl != drive_cyl) || (rec_q.sect >= SECT_W'(NUM_SECT));
        eoc_eff   = eoc_q && !cmd_start;
        do_load   = idle && ld_any;
        do_chk    = idle && !ld_any && chk_start;
        do_adv    = idle && !ld_any && !chk_start && adv;
        adv_ok    = do_adv && !eoc_eff && !addr_bad;
        adv_err   = do_adv && !eoc_eff && addr_bad;
        chk_cnt   = data_in[CNT_W-1:0];
        chk_lim   = span_left(rec_q.head[0], rec_q.sect);
        chk_over  = SUM_W'(chk_cnt) > chk_lim;
        chk_sum   = SUM_W'(rec_q.sect) + SUM_W'(chk_cnt);
        div_start = do_chk && !addr_bad && !chk_over;
    end

    rar_lin_addr u_lin (
        .rec       (rec_q),
        .word_addr (lin_now)
    );

    rar_divmod #(
        .W    (SUM_W),
        .RW   (SECT_W),
        .DIVV (NUM_SECT)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (div_start),
        .dividend (chk_sum),
        .busy     (div_busy),
        .done     (div_done),
        .rem      (div_rem),
        .quo_lsb  (div_qlsb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q   <= '0;
            eoc_q   <= 1'b0;
            grant_q <= 1'b0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
            acc_q   <= '0;
        end else begin
            grant_q <= 1'b0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;

            if (cmd_start) begin
                eoc_q <= 1'b0;
            end

            if (do_load) begin
                if (ld_cyl) begin
                    rec_q.cyl <= data_in[CYL_W-1:0];
                end
                if (ld_hs) begin
                    rec_q.head <= data_in[HEAD_LSB +: HEAD_W];
                    rec_q.sect <= data_in[SECT_W-1:0];
                end
            end

            if (adv_ok) begin
                grant_q <= 1'b1;
                acc_q   <= lin_now;
                if (rec_q.sect == SECT_W'(NUM_SECT - 1)) begin
                    rec_q.sect    <= '0;
                    rec_q.head[0] <= ~rec_q.head[0];
                    if (rec_q.head[0]) begin
                        eoc_q <= 1'b1;
                    end
                end else begin
                    rec_q.sect <= rec_q.sect + SECT_W'(1);
                end
            end

            if (adv_err) begin
                err_q <= 1'b1;
            end

            if (do_chk) begin
                if (addr_bad) begin
                    err_q  <= 1'b1;
                    done_q <= 1'b1;
                end else if (chk_over) begin
                    eoc_q         <= 1'b1;
                    rec_q.head[0] <= 1'b0;
                    rec_q.sect    <= '0;
                    done_q        <= 1'b1;
                end
            end

            if (div_done) begin
                rec_q.sect    <= div_rem;
                rec_q.head[0] <= rec_q.head[0] ^ div_qlsb;
                done_q        <= 1'b1;
            end
        end
    end

    assign cyl      = rec_q.cyl;
    assign head     = rec_q.head;
    assign sect     = rec_q.sect;
    assign eoc      = eoc_q;
    assign grant    = grant_q;
    assign addr_err = err_q;
    assign acc_addr = acc_q;
    assign chk_busy = div_busy;
    assign chk_done = done_q;

endmodule

// File: rtl/rar_unit_sva.sv
module rar_unit_sva
    import rar_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        ld_cyl,
    input logic        ld_hs,
    input logic        cmd_start,
    input logic        adv,
    input logic        chk_start,
    input logic [7:0]  cyl,
    input logic [4:0]  head,
    input logic [4:0]  sect,
    input logic        eoc,
    input logic        grant,
    input logic        addr_err,
    input logic [23:0] acc_addr,
    input logic        chk_busy,
    input logic        chk_done
);

    a_r5_err_excl: assert property (@(posedge clk) disable iff (rst)
        !(addr_err && grant));

    a_r3_grant_sector: assert property (@(posedge clk) disable iff (rst)
        grant |-> ((int'(acc_addr) % (NUM_SECT * SECT_WORDS)) == int'($past(sect)) * SECT_WORDS));

    a_r4_sector_range: assert property (@(posedge clk) disable iff (rst)
        grant |-> (int'(sect) < NUM_SECT));

    a_r5_err_hold: assert property (@(posedge clk) disable iff (rst)
        addr_err |-> ($stable(cyl) && $stable(head) && $stable(sect)));

    a_r12_busy_hold: assert property (@(posedge clk) disable iff (rst)
        chk_busy |-> ($stable(cyl) && $stable(head) && $stable(sect)));

    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        chk_done |-> !chk_busy);

    a_r6_eoc_block: assert property (@(posedge clk) disable iff (rst)
        (eoc && adv && !cmd_start && !chk_busy && !ld_cyl && !ld_hs && !chk_start)
        |=> (!grant && !addr_err));

    a_r7_cmd_clear: assert property (@(posedge clk) disable iff (rst)
        (cmd_start && !adv && !chk_start && !chk_busy) |=> !eoc);

endmodule

bind rar_unit rar_unit_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .ld_cyl    (ld_cyl),
    .ld_hs     (ld_hs),
    .cmd_start (cmd_start),
    .adv       (adv),
    .chk_start (chk_start),
    .cyl       (cyl),
    .head      (head),
    .sect      (sect),
    .eoc       (eoc),
    .grant     (grant),
    .addr_err  (addr_err),
    .acc_addr  (acc_addr),
    .chk_busy  (chk_busy),
    .chk_done  (chk_done)
);

// File: tb/rar_unit_bench.sv
`timescale 1ns/1ps
module rar_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [12:0] data_in;
    logic        ld_cyl, ld_hs, cmd_start, adv, chk_start;
    logic [7:0]  drive_cyl;
    logic [7:0]  cyl;
    logic [4:0]  head, sect;
    logic        eoc, grant, addr_err, chk_busy, chk_done;
    logic [23:0] acc_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    rar_unit u_rar_unit (
        .clk(clk), .rst(rst), .data_in(data_in), .ld_cyl(ld_cyl), .ld_hs(ld_hs),
        .cmd_start(cmd_start), .adv(adv), .chk_start(chk_start), .drive_cyl(drive_cyl),
        .cyl(cyl), .head(head), .sect(sect), .eoc(eoc), .grant(grant),
        .addr_err(addr_err), .acc_addr(acc_addr), .chk_busy(chk_busy), .chk_done(chk_done)
    );

    // cyl, head, sect, drive_cyl, exp_grant, exp_err, exp_head, exp_sect, exp_eoc
    localparam int NV = 8;
    localparam logic [38:0] VEC [NV] = '{
        {8'd10,  5'd4,  5'd5,  8'd10,  1'b1, 1'b0, 5'd4,  5'd6,  1'b0},
        {8'd0,   5'd0,  5'd22, 8'd0,   1'b1, 1'b0, 5'd1,  5'd0,  1'b0},
        {8'd5,   5'd3,  5'd22, 8'd5,   1'b1, 1'b0, 5'd2,  5'd0,  1'b1},
        {8'd7,   5'd2,  5'd1,  8'd8,   1'b0, 1'b1, 5'd2,  5'd1,  1'b0},
        {8'd7,   5'd2,  5'd23, 8'd7,   1'b0, 1'b1, 5'd2,  5'd23, 1'b0},
        {8'd202, 5'd19, 5'd22, 8'd202, 1'b1, 1'b0, 5'd18, 5'd0,  1'b1},
        {8'd1,   5'd0,  5'd0,  8'd1,   1'b1, 1'b0, 5'd0,  5'd1,  1'b0},
        {8'd100, 5'd17, 5'd10, 8'd100, 1'b1, 1'b0, 5'd17, 5'd11, 1'b0}
    };

    function automatic int lin(int c, int h, int s);
        return ((c * 20 + h) * 23 + s) * 128;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic load_addr(int c, int h, int s);
        data_in = 13'(c);
        ld_cyl  = 1'b1;
        tick();
        ld_cyl  = 1'b0;
        data_in = {h[4:0], 3'b000, s[4:0]};
        ld_hs   = 1'b1;
        tick();
        ld_hs   = 1'b0;
    endtask

    task automatic new_cmd();
        cmd_start = 1'b1;
        tick();
        cmd_start = 1'b0;
    endtask

    // Start a check; return samples until chk_done is seen.
    task automatic run_check(logic [12:0] word, output int lat, output bit err_seen);
        data_in   = word;
        chk_start = 1'b1;
        tick();
        chk_start = 1'b0;
        lat = 1;
        err_seen = addr_err;
        while (!chk_done && lat < 10) begin
            tick();
            lat++;
            err_seen = err_seen | addr_err;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int lat;
        bit es;
        rst = 1'b1; data_in = '0; ld_cyl = 0; ld_hs = 0; cmd_start = 0;
        adv = 0; chk_start = 0; drive_cyl = '0;
        tick(); tick();
        // R1: reset state
        expect_eq("R1", "fields", {cyl, head, sect}, 0);
        expect_eq("R1", "flags", {eoc, grant, addr_err, chk_busy, chk_done}, 0);
        rst = 1'b0;
        tick();
        expect_eq("R1", "after release", {cyl, head, sect, eoc, grant, addr_err, chk_busy, chk_done}, 0);

        // R2: loads
        load_addr(171, 13, 9);
        expect_eq("R2", "cyl", cyl, 171);
        expect_eq("R2", "head", head, 13);
        expect_eq("R2", "sect", sect, 9);

        // Table walk: R3 R4 R5
        for (int i = 0; i < NV; i++) begin
            logic [7:0] c, d;
            logic [4:0] h, s, eh, es5;
            logic eg, ee, ee2;
            {c, h, s, d, eg, ee, eh, es5, ee2} = VEC[i];
            new_cmd();
            load_addr(c, h, s);
            drive_cyl = d;
            adv = 1'b1;
            tick();
            adv = 1'b0;
            expect_eq(ee ? "R5" : "R3", "grant", grant, eg);
            expect_eq(ee ? "R5" : "R3", "addr_err", addr_err, ee);
            if (eg) expect_eq("R3", "acc_addr", acc_addr, lin(c, h, s));
            expect_eq("R4", "head", head, eh);
            expect_eq("R4", "sect", sect, es5);
            expect_eq("R4", "eoc", eoc, ee2);
            expect_eq("R5", "cyl kept", cyl, c);
        end

        // R9: overflow from even track
        new_cmd();
        load_addr(3, 0, 20); drive_cyl = 8'd3;
        run_check(13'd30, lat, es);
        expect_eq("R9", "latency", lat, 1);
        expect_eq("R9", "eoc", eoc, 1);
        expect_eq("R9", "head", head, 0);
        expect_eq("R9", "sect", sect, 0);

        // R10: no wrap, upper bits of word ignored (bits 12:9 set, count 5 -> s 15)
        new_cmd();
        load_addr(3, 0, 10);
        run_check(13'h1E05, lat, es);
        expect_eq("R10", "latency q0", lat, 2);
        expect_eq("R10", "sect", sect, 15);
        expect_eq("R10", "head", head, 0);
        expect_eq("R10", "eoc", eoc, 0);

        // R10: one wrap, s = 30
        load_addr(3, 2, 20);
        run_check(13'd10, lat, es);
        expect_eq("R10", "latency q1", lat, 3);
        expect_eq("R10", "sect", sect, 7);
        expect_eq("R10", "head", head, 3);

        // R10: exact limit, s = 46
        load_addr(3, 4, 0);
        run_check(13'd46, lat, es);
        expect_eq("R10", "latency q2", lat, 4);
        expect_eq("R10", "sect", sect, 0);
        expect_eq("R10", "head", head, 4);
        expect_eq("R10", "eoc", eoc, 0);

        // R10: odd track at limit, s = 23
        load_addr(3, 1, 0);
        run_check(13'd23, lat, es);
        expect_eq("R10", "odd head", head, 0);
        expect_eq("R10", "odd sect", sect, 0);

        // R11: check with cylinder mismatch
        load_addr(3, 6, 4); drive_cyl = 8'd9;
        run_check(13'd2, lat, es);
        expect_eq("R11", "latency", lat, 1);
        expect_eq("R11", "addr_err", es, 1);
        expect_eq("R11", "sect kept", sect, 4);
        drive_cyl = 8'd3;

        // R12: requests during a check are ignored
        load_addr(3, 2, 20);
        data_in = 13'd10; chk_start = 1'b1; tick(); chk_start = 1'b0;
        expect_eq("R12", "busy", chk_busy, 1);
        adv = 1'b1; ld_hs = 1'b1; data_in = {5'd9, 3'b000, 5'd2};
        tick();
        adv = 1'b0; ld_hs = 1'b0;
        expect_eq("R12", "no grant", grant, 0);
        while (!chk_done && chk_busy) tick();
        expect_eq("R12", "sect", sect, 7);
        expect_eq("R12", "head", head, 3);

        // R6: eoc blocks advance (overflow: head 1 sect 1 count 23)
        new_cmd();
        load_addr(3, 1, 1);
        run_check(13'd23, lat, es);
        expect_eq("R9", "eoc odd", eoc, 1);
        adv = 1'b1; tick(); adv = 1'b0;
        expect_eq("R6", "grant", grant, 0);
        expect_eq("R6", "addr_err", addr_err, 0);
        expect_eq("R6", "sect", sect, 0);

        // R7: cmd_start with advance in same cycle
        cmd_start = 1'b1; adv = 1'b1; tick(); cmd_start = 1'b0; adv = 1'b0;
        expect_eq("R7", "grant", grant, 1);
        expect_eq("R7", "acc_addr", acc_addr, lin(3, 0, 0));
        expect_eq("R7", "sect", sect, 1);
        expect_eq("R7", "eoc", eoc, 0);

        // R8: load with advance in same cycle
        data_in = {5'd5, 3'b000, 5'd9}; ld_hs = 1'b1; adv = 1'b1;
        tick();
        ld_hs = 1'b0; adv = 1'b0;
        expect_eq("R8", "grant", grant, 0);
        expect_eq("R8", "head", head, 5);
        expect_eq("R8", "sect", sect, 9);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule